// File: doc/BRIEF.md
# SPI serial EEPROM target model

This block is a synthesizable model of a small serial EEPROM that sits on the target side of a four-wire SPI link. It holds a 4096-byte array in on-chip storage. It decodes a one-byte opcode, then a two-byte address and any data bytes that follow. A status byte reports a write-enable latch and a busy flag. Page programming and status writes run as a timed internal cycle that is counted in system clocks.

The serial pins are asynchronous to the system clock. They are synchronised, and their edges are detected inside the clock domain. The link runs in SPI mode 0: the target samples MOSI when SCK rises, changes MISO after SCK falls, and sends the most significant bit of each byte first. Write data is gathered in a 32-byte page buffer. It is committed only when chip select is released on a byte boundary. During the busy window that follows, only the status read is served.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00: the busy flag (bit 0), the write-enable latch (bit 1), the protect field (bits 3:2) and the protect-lock bit (bit 7) are all clear.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 returns the status byte in every byte that follows the opcode while chip select stays low.
- R3: An array write (opcode 0x02) or a status write (opcode 0x01) sent while the write-enable latch is clear changes no stored byte and starts no busy window.
- R4: An array read (opcode 0x03) takes a high address byte and then a low address byte. The stored byte at that address appears on MISO in the next byte, MSB first. Data written with opcode 0x02 at an address reads back unchanged.
- R5: Write data is stored at consecutive addresses. Past the last byte of a 32-byte page it wraps to the first byte of the same page.
- R6: When chip select is released after a complete write, the busy flag is set for WRITE_CYCLES system clocks. When the busy window ends, both the busy flag and the write-enable latch clear.
- R7: While the busy flag is set, every opcode except 0x05 is ignored: reads return 0x00 bytes, writes store nothing, and 0x04 leaves the latch set.
- R8: A read continues for as long as chip select stays low. It crosses page boundaries, and after address 4095 it continues at address 0.
- R9: A status write updates only bits 7, 3 and 2 of the status byte, and only when its busy window ends. The other bits written are ignored.
- R10: A write whose chip select is released in the middle of a byte commits nothing and starts no busy window. The write-enable latch stays set.
- R11: Only the low 12 address bits select a byte: the top four bits of the high address byte are ignored.
- R12: An opcode outside the six listed is ignored and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, driven low while deselected |

## Verification
Each pin passes two synchroniser stages and one edge register, so an SCK or chip-select edge reaches the decoder three system clocks after the pin moves. The next MISO bit then settles one clock later. The bench holds each SCK phase for eight clocks and samples MISO just before it raises SCK, so every bit has settled with margin. A busy window opens about four clocks after chip select rises and lasts WRITE_CYCLES clocks. The bench reads status at once, well inside the window, to see the busy flag. It waits WRITE_CYCLES plus a margin before it expects the flag and the latch to be clear, and before it reads back the array.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    // Opcode values decoded from the first byte of a selection
    localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
    localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;
    localparam logic [7:0] CMD_ARRAY_RD  = 8'h03;
    localparam logic [7:0] CMD_ARRAY_WR  = 8'h02;

    // Position inside one chip-select window
    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_RD_DATA,
        PH_WR_DATA,
        PH_STAT_OUT,
        PH_STAT_IN,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_start,
    output logic sel_end,
    output logic sel_act,
    output logic mosi_s
);
    localparam int NSIG = 3;
    // bit 0 sck (idle low), bit 1 cs_n (idle high), bit 2 mosi
    localparam logic [NSIG-1:0] IDLE = 3'b010;

    logic [STAGES-1:0][NSIG-1:0] sync_q;
    logic [1:0]                  last_q;
    logic [NSIG-1:0]             cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {STAGES{IDLE}};
            last_q <= IDLE[1:0];
        end else begin
            sync_q[0] <= {mosi, cs_n, sck};
            for (int s = 1; s < STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
            last_q <= sync_q[STAGES-1][1:0];
        end
    end

    assign cur       = sync_q[STAGES-1];
    assign sck_rise  = cur[0] & ~last_q[0];
    assign sck_fall  = ~cur[0] & last_q[0];
    assign sel_start = ~cur[1] & last_q[1];
    assign sel_end   = cur[1] & ~last_q[1];
    assign sel_act   = ~cur[1];
    assign mosi_s    = cur[2];

endmodule

// File: rtl/spi_eeprom_array.sv
module spi_eeprom_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_eeprom_pagebuf.sv
module spi_eeprom_pagebuf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PG_W-1:0]   widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PG_W-1:0]   ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              any
);
    logic [DATA_W-1:0] data_q [PAGE_BYTES];
    logic              vld_q  [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                vld_q[i]  <= 1'b0;
            end else if (clr) begin
                vld_q[i]  <= 1'b0;
            end else if (wr && widx == PG_W'(i)) begin
                data_q[i] <= wdata;
                vld_q[i]  <= 1'b1;
            end
        end
    end

    always_comb begin
        any = 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            any = any | vld_q[i];
        end
    end

    assign rdata  = data_q[ridx];
    assign rvalid = vld_q[ridx];

endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
    parameter int ADDR_W       = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 5000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    import spi_eeprom_pkg::*;

    localparam int PG_W    = $clog2(PAGE_BYTES);
    localparam int HI_W    = ADDR_W - 8;
    localparam int JOB_LEN = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES + 1;
    localparam int CNT_W   = $clog2(JOB_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JOB_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        bitn;
        logic [6:0]        rx;
        logic [7:0]        tx;
        logic [7:0]        tx_nxt;
        logic              ld_pend;
        logic              wr_cmd;
        logic [HI_W-1:0]   addr_hi;
        logic [ADDR_W-1:0] addr;
        logic              wel;
        logic              wip;
        logic              srwd;
        logic [1:0]        bp;
        logic              sr_srwd;
        logic [1:0]        sr_bp;
        logic              sr_got;
        logic              job_stat;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t st_d, st_q;

    logic sck_rise, sck_fall, sel_start, sel_end, sel_act, mosi_s;
    logic [7:0]        byte_now;
    logic [7:0]        status_now;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        slot_data;
    logic              slot_vld;
    logic              buf_any;
    logic              buf_clr;
    logic              buf_wr;
    logic              busy_flag;
    logic              latch_flag;

    spi_eeprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .sel_act   (sel_act),
        .mosi_s    (mosi_s)
    );

    spi_eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (slot_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    spi_eeprom_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_pagebuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .wr     (buf_wr),
        .widx   (st_q.addr[PG_W-1:0]),
        .wdata  (byte_now),
        .ridx   (st_q.cnt[PG_W-1:0]),
        .rdata  (slot_data),
        .rvalid (slot_vld),
        .any    (buf_any)
    );

    assign byte_now   = {st_q.rx, mosi_s};
    assign status_now = {st_q.srwd, 3'b000, st_q.bp, st_q.wel, st_q.wip};
    assign rd_addr    = (st_q.phase == PH_ADDR_LO) ? {st_q.addr_hi, byte_now} : st_q.addr;
    assign mem_waddr  = {st_q.addr[ADDR_W-1:PG_W], st_q.cnt[PG_W-1:0]};
    assign miso       = sel_act ? st_q.tx[7] : 1'b0;
    assign busy_flag  = st_q.wip;
    assign latch_flag = st_q.wel;

    always_comb begin
        st_d    = st_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        mem_we  = 1'b0;

        // Internal write cycle: commit the page in its first clocks
        if (st_q.wip) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (!st_q.job_stat && st_q.cnt < CNT_PAGE) begin
                mem_we = slot_vld;
            end
            if (st_q.cnt == CNT_LAST) begin
                st_d.wip = 1'b0;
                st_d.wel = 1'b0;
                st_d.cnt = '0;
                if (st_q.job_stat) begin
                    st_d.srwd = st_q.sr_srwd;
                    st_d.bp   = st_q.sr_bp;
                end
            end
        end

        if (sel_start) begin
            st_d.phase   = PH_OPCODE;
            st_d.bitn    = '0;
            st_d.tx      = '0;
            st_d.ld_pend = 1'b0;
            st_d.sr_got  = 1'b0;
        end else if (sel_end) begin
            if (!st_q.wip && st_q.bitn == 3'd0) begin
                if (st_q.phase == PH_WR_DATA && buf_any) begin
                    st_d.wip      = 1'b1;
                    st_d.job_stat = 1'b0;
                    st_d.cnt      = '0;
                end else if (st_q.sr_got) begin
                    st_d.wip      = 1'b1;
                    st_d.job_stat = 1'b1;
                    st_d.cnt      = '0;
                end
            end
            st_d.sr_got = 1'b0;
            st_d.phase  = PH_SKIP;
        end else if (sel_act) begin
            if (sck_rise) begin
                st_d.rx   = byte_now[6:0];
                st_d.bitn = st_q.bitn + 3'd1;
                if (st_q.bitn == 3'd7) begin
                    unique case (st_q.phase)
                        PH_OPCODE: begin
                            st_d.phase = PH_SKIP;
                            if (!st_q.wip || byte_now == CMD_STAT_RD) begin
                                case (byte_now)
                                    CMD_LATCH_ON:  st_d.wel = 1'b1;
                                    CMD_LATCH_OFF: st_d.wel = 1'b0;
                                    CMD_STAT_RD: begin
                                        st_d.tx_nxt  = status_now;
                                        st_d.ld_pend = 1'b1;
                                        st_d.phase   = PH_STAT_OUT;
                                    end
                                    CMD_STAT_WR: begin
                                        if (st_q.wel) st_d.phase = PH_STAT_IN;
                                    end
                                    CMD_ARRAY_RD: begin
                                        st_d.wr_cmd = 1'b0;
                                        st_d.phase  = PH_ADDR_HI;
                                    end
                                    CMD_ARRAY_WR: begin
                                        if (st_q.wel) begin
                                            st_d.wr_cmd = 1'b1;
                                            st_d.phase  = PH_ADDR_HI;
                                            buf_clr     = 1'b1;
                                        end
                                    end
                                    default: st_d.phase = PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR_HI: begin
                            st_d.addr_hi = byte_now[HI_W-1:0];
                            st_d.phase   = PH_ADDR_LO;
                        end
                        PH_ADDR_LO: begin
                            if (st_q.wr_cmd) begin
                                st_d.addr  = rd_addr;
                                st_d.phase = PH_WR_DATA;
                            end else begin
                                st_d.tx_nxt  = rd_data;
                                st_d.ld_pend = 1'b1;
                                st_d.addr    = rd_addr + ADDR_W'(1);
                                st_d.phase   = PH_RD_DATA;
                            end
                        end
                        PH_RD_DATA: begin
                            st_d.tx_nxt  = rd_data;
                            st_d.ld_pend = 1'b1;
                            st_d.addr    = st_q.addr + ADDR_W'(1);
                        end
                        PH_WR_DATA: begin
                            buf_wr    = 1'b1;
                            st_d.addr = {st_q.addr[ADDR_W-1:PG_W],
                                         st_q.addr[PG_W-1:0] + PG_W'(1)};
                        end
                        PH_STAT_OUT: begin
                            st_d.tx_nxt  = status_now;
                            st_d.ld_pend = 1'b1;
                        end
                        PH_STAT_IN: begin
                            st_d.sr_srwd = byte_now[7];
                            st_d.sr_bp   = byte_now[3:2];
                            st_d.sr_got  = 1'b1;
                            st_d.phase   = PH_SKIP;
                        end
                        PH_SKIP: st_d.phase = PH_SKIP;
                        default: st_d.phase = PH_SKIP;
                    endcase
                end
            end else if (sck_fall) begin
                if (st_q.ld_pend) begin
                    st_d.tx      = st_q.tx_nxt;
                    st_d.ld_pend = 1'b0;
                end else begin
                    st_d.tx = {st_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_SKIP;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_eeprom_model_chk.sv
module spi_eeprom_model_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic latch,
    input logic sel_start,
    input logic sel_end,
    input logic sck_fall,
    input logic miso,
    input logic mem_we
);
    // R6: a busy window opens only when chip select has just been released
    assert_busy_from_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_end));

    // R3: a busy window needs the write-enable latch set beforehand
    assert_busy_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(latch));

    // R6: the latch is clear once the busy window closes
    assert_latch_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !latch);

    // R7: the array is written only inside a busy window
    assert_store_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R4: MISO moves only after a falling SCK edge or a select change
    assert_miso_mode0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sck_fall) && !$past(sel_start) && !sel_start && !sel_end) |-> $stable(miso));

endmodule

bind spi_eeprom_model spi_eeprom_model_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_flag),
    .latch     (latch_flag),
    .sel_start (sel_start),
    .sel_end   (sel_end),
    .sck_fall  (sck_fall),
    .miso      (miso),
    .mem_we    (mem_we)
);

// File: tb/spi_eeprom_model_tb.sv
`timescale 1ns/1ps
module spi_eeprom_model_tb;
    localparam int WC = 2000;   // write cycle length used in the bench
    localparam int HP = 8;      // system clocks per SCK phase

    // Table: {address[11:0], data[7:0]} written one byte at a time, then read back
    localparam logic [19:0] VECS [8] = '{
        20'h000A5, 20'h03F5A, 20'h0503C, 20'hFFF96,
        20'h7E0C3, 20'h123E1, 20'h8000F, 20'h02078
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    logic [7:0] s;

    always #4 clk = ~clk;

    spi_eeprom_model #(.WRITE_CYCLES(WC)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .cs_n  (cs_n),
        .mosi  (mosi),
        .miso  (miso)
    );

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            ticks(HP);
            r[i] = miso;
            sck = 1'b1;
            ticks(HP);
            sck = 1'b0;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        ticks(HP);
    endtask

    task automatic sel_off();
        ticks(HP);
        cs_n = 1'b1;
        ticks(2 * HP);
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [7:0] r;
        sel_on();
        spi_byte(op, r);
        sel_off();
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [7:0] r;
        sel_on();
        spi_byte(8'h05, r);
        spi_byte(8'h00, st);
        sel_off();
    endtask

    task automatic status_write(input logic [7:0] v);
        logic [7:0] r;
        sel_on();
        spi_byte(8'h01, r);
        spi_byte(v, r);
        sel_off();
    endtask

    task automatic array_write(input logic [15:0] a, input int n);
        logic [7:0] r;
        sel_on();
        spi_byte(8'h02, r);
        spi_byte(a[15:8], r);
        spi_byte(a[7:0], r);
        for (int i = 0; i < n; i++) spi_byte(wbuf[i], r);
        sel_off();
    endtask

    task automatic array_read(input logic [15:0] a, input int n);
        logic [7:0] r;
        sel_on();
        spi_byte(8'h03, r);
        spi_byte(a[15:8], r);
        spi_byte(a[7:0], r);
        for (int i = 0; i < n; i++) spi_byte(8'h00, rbuf[i]);
        sel_off();
    endtask

    task automatic wait_job();
        ticks(WC + 200);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        ticks(5);
        rst_n = 1'b1;
        ticks(5);

        // R1: status after reset
        read_status(s);
        check("R1 reset status", s, 8'h00);

        // R2: latch set, repeated status bytes, latch cleared
        op_only(8'h06);
        sel_on();
        spi_byte(8'h05, s);
        spi_byte(8'h00, s);
        check("R2 latch set", s, 8'h02);
        spi_byte(8'h00, s);
        check("R2 status repeats", s, 8'h02);
        sel_off();
        op_only(8'h04);
        read_status(s);
        check("R2 latch cleared", s, 8'h00);

        // R4: table of single-byte writes, each read back
        for (int v = 0; v < 8; v++) begin
            op_only(8'h06);
            wbuf[0] = VECS[v][7:0];
            array_write({4'h0, VECS[v][19:8]}, 1);
            wait_job();
            array_read({4'h0, VECS[v][19:8]}, 1);
            check("R4 table readback", rbuf[0], VECS[v][7:0]);
        end

        // R3: write without latch is ignored
        wbuf[0] = 8'h11;
        array_write(16'h0000, 1);
        read_status(s);
        check("R3 no busy without latch", s, 8'h00);
        wait_job();
        array_read(16'h0000, 1);
        check("R3 byte kept", rbuf[0], 8'hA5);

        // R6: busy window then auto-cleared latch; R4 multi-byte page write
        op_only(8'h06);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'(i + 1);
        array_write(16'h0040, 4);
        read_status(s);
        check("R6 busy and latch during cycle", s, 8'h03);
        wait_job();
        read_status(s);
        check("R6 both clear after cycle", s, 8'h00);
        array_read(16'h0040, 4);
        for (int i = 0; i < 4; i++) check("R4 sequential page data", rbuf[i], 8'(i + 1));

        // R7: commands during busy are ignored
        op_only(8'h06);
        wbuf[0] = 8'h55;
        array_write(16'h0060, 1);
        array_read(16'h0040, 1);
        check("R7 read while busy", rbuf[0], 8'h00);
        wbuf[0] = 8'hEE;
        array_write(16'h0041, 1);
        op_only(8'h04);
        read_status(s);
        check("R7 latch-off ignored while busy", s, 8'h03);
        wait_job();
        array_read(16'h0041, 1);
        check("R7 write while busy dropped", rbuf[0], 8'h02);
        array_read(16'h0060, 1);
        check("R7 first write committed", rbuf[0], 8'h55);

        // R5: page wrap
        op_only(8'h06);
        wbuf[0] = 8'h10; wbuf[1] = 8'h20; wbuf[2] = 8'h30;
        array_write(16'h009E, 3);
        wait_job();
        array_read(16'h0080, 1);
        check("R5 wrapped to page start", rbuf[0], 8'h30);
        array_read(16'h009E, 2);
        check("R5 byte at 0x09E", rbuf[0], 8'h10);
        check("R5 byte at 0x09F", rbuf[1], 8'h20);

        // R8: read across a page boundary and past the top address
        array_read(16'h003F, 2);
        check("R8 page crossing low", rbuf[0], 8'h5A);
        check("R8 page crossing high", rbuf[1], 8'h01);
        array_read(16'h0FFF, 2);
        check("R8 last byte", rbuf[0], 8'h96);
        check("R8 wrap to zero", rbuf[1], 8'hA5);

        // R11: upper address bits ignored
        array_read(16'hF040, 1);
        check("R11 high nibble ignored", rbuf[0], 8'h01);

        // R10: chip select released mid-byte
        op_only(8'h06);
        sel_on();
        spi_byte(8'h02, s);
        spi_byte(8'h00, s);
        spi_byte(8'h50, s);
        spi_byte(8'h77, s);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            ticks(HP);
            sck = 1'b1;
            ticks(HP);
            sck = 1'b0;
        end
        sel_off();
        read_status(s);
        check("R10 no busy, latch kept", s, 8'h02);
        wait_job();
        array_read(16'h0050, 1);
        check("R10 byte unchanged", rbuf[0], 8'h3C);
        op_only(8'h04);

        // R12: unknown opcode ignored
        op_only(8'h06);
        op_only(8'hAB);
        read_status(s);
        check("R12 unknown opcode", s, 8'h02);
        op_only(8'h04);

        // R9: status write
        op_only(8'h06);
        status_write(8'hFF);
        read_status(s);
        check("R9 status unchanged during cycle", s, 8'h03);
        wait_job();
        read_status(s);
        check("R9 writable bits only", s, 8'h8C);
        status_write(8'h00);
        read_status(s);
        check("R3 status write needs latch", s, 8'h8C);
        op_only(8'h06);
        status_write(8'h00);
        wait_job();
        read_status(s);
        check("R9 status restored", s, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule